// File: doc/BRIEF.md
# Many-to-One Flow-Controlled Switch

This block merges several input streams onto one shared output link. Each input port feeds its own small elastic buffer, and each buffer uses a valid/ready handshake. A round-robin arbiter looks at the buffers that hold a flit and picks one of them. A multiplexer then forwards the chosen flit into an output elastic buffer, and that buffer drives the output port under the same handshake.

The output buffer returns a single ready signal that is shared by all inputs. A grant therefore turns into a transfer only while that ready is high. The dequeue acknowledge goes back to the winning input buffer alone. The arbiter keeps one-hot priority state, and that state moves only on a real transfer. While the output side is full, nothing is consumed and the priority stays where it is.

A parameter selects the buffer type. A 1-slot buffer is the smallest choice and passes at most one flit every other cycle. A 2-slot buffer keeps its ready registered and still sustains one flit per cycle.

Top module: `many_to_one_switch`

## Requirements
- R1: After reset, `out_valid` is 0, every bit of `in_ready` is 1, and input 0 holds the highest priority.
- R2: In each cycle the grant goes to the first input that holds a flit, scanning upward and cyclically from the highest-priority position. An input that holds no flit is never granted.
- R3: After a transfer from input k, the highest priority moves to input k+1. After input N-1 it wraps to input 0.
- R4: While the output buffer has no free slot, no input buffer dequeues and the priority state does not change. While `out_ready` is low, a presented output flit stays valid and stable.
- R5: At most one input buffer dequeues in any cycle, and that buffer is the granted one. Every other input buffer sees its dequeue-ready signal low.
- R6: Every flit accepted at an input leaves `out_data` exactly once with its bits unchanged, and flits from the same input leave in the order they were accepted.
- R7: An input that keeps a flit waiting is served within N transfers of the shared output.
- R8: With SLOTS=2, a single input held valid with `out_ready` high produces one output flit in every cycle once the pipe is full.
- R9: With SLOTS=1, each buffer passes at most one flit every other cycle, so `out_valid` is never high in two consecutive cycles while `out_ready` is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Per-input flit valid |
| in_ready | output | N_PORTS | Per-input buffer space available |
| in_data | input | N_PORTS*FLIT_W | Input flits, input i in bits [i*FLIT_W +: FLIT_W] |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream accepts the output flit |
| out_data | output | FLIT_W | Output flit |

## Verification
Two things can happen in the same cycle: the output buffer frees a slot, and the arbiter holds a grant that the full buffer cannot yet accept. The bench provokes this by filling the switch with every input backlogged and `out_ready` low. It then raises `out_ready` for exactly one cycle. It judges the result at the ports. Only input 2's `in_ready` may rise, because one flit from input 0 and one from input 1 had already moved. After the full release, the output order must continue 0,1,2,3,... with no gap and no repeat, which shows the stalled cycles neither consumed a flit nor moved the priority.

// File: rtl/m2o_pkg.sv
package m2o_pkg;

  // Buffer flavours selectable through the SLOTS parameter.
  localparam int SLOTS_SINGLE = 1;
  localparam int SLOTS_DOUBLE = 2;

  // Cyclic successor of a port index in a ring of n ports.
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/elastic_buf.sv
module elastic_buf #(
  parameter int W     = 16,
  parameter int SLOTS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic push;
  logic pop;

  assign push = in_valid & in_ready;
  assign pop  = out_valid & out_ready;

  if (SLOTS == m2o_pkg::SLOTS_SINGLE) begin : g_one
    logic         full;
    logic [W-1:0] hold;

    assign in_ready  = ~full;
    assign out_valid = full;
    assign out_data  = hold;

    always_ff @(posedge clk) begin
      if (!rst_n)    full <= 1'b0;
      else if (push) full <= 1'b1;
      else if (pop)  full <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (push) hold <= in_data;
    end

    // R9: a single slot cannot refill in the cycle it drains
    assert_alt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !out_valid);
  end else begin : g_two
    logic [W-1:0] mem [2];
    logic         wp;
    logic         rp;
    logic [1:0]   cnt;

    assign in_ready  = (cnt != 2'd2);
    assign out_valid = (cnt != 2'd0);
    assign out_data  = mem[rp];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= 1'b0;
        rp  <= 1'b0;
        cnt <= 2'd0;
      end else begin
        if (push) wp <= ~wp;
        if (pop)  rp <= ~rp;
        cnt <= cnt + {1'b0, push} - {1'b0, pop};
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= in_data;
    end
  end

  // R4 R6: a presented flit is held until it is taken
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         fire,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] prio;

  // First request found scanning cyclically from the one-hot priority mark.
  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] r, input logic [N-1:0] p);
    logic [N-1:0] g;
    int           idx;
    logic         done;
    g    = '0;
    idx  = 0;
    done = 1'b0;
    for (int i = 0; i < N; i++) if (p[i]) idx = i;
    for (int k = 0; k < N; k++) begin
      if (!done && r[IW'(idx)]) begin
        g[IW'(idx)] = 1'b1;
        done        = 1'b1;
      end
      idx = m2o_pkg::ring_next(idx, N);
    end
    return g;
  endfunction

  // Position after the winner becomes the new highest priority.
  function automatic logic [N-1:0] rr_advance(input logic [N-1:0] g);
    return {g[N-2:0], g[N-1]};
  endfunction

  assign gnt = rr_pick(req, prio);

  always_ff @(posedge clk) begin
    if (!rst_n)    prio <= {{(N-1){1'b0}}, 1'b1};
    else if (fire) prio <= rr_advance(gnt);
  end

  assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_gnt_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  assert_gnt_any_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
  assert_prio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(prio));
  assert_prio_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((prio & $past(gnt)) == '0));

endmodule

// File: rtl/flit_mux.sv
module flit_mux #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] din,
  output logic [W-1:0]   dout
);
  logic [W-1:0] masked [N];

  for (genvar i = 0; i < N; i++) begin : g_and
    assign masked[i] = din[i*W +: W] & {W{sel[i]}};
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) dout = dout | masked[i];
  end

endmodule

// File: rtl/many_to_one_switch.sv
module many_to_one_switch #(
  parameter int N_PORTS = 4,
  parameter int FLIT_W  = 16,
  parameter int SLOTS   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PORTS-1:0]    in_valid,
  output logic [N_PORTS-1:0]    in_ready,
  input  logic [N_PORTS*FLIT_W-1:0] in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [FLIT_W-1:0]     out_data
);
  localparam int N = N_PORTS;
  localparam int W = FLIT_W;

  logic [N-1:0]   q_valid;
  logic [N-1:0]   q_ready;
  logic [N*W-1:0] q_data;
  logic [N-1:0]   gnt;
  logic [N-1:0]   deq;
  logic [W-1:0]   mux_data;
  logic           mux_valid;
  logic           ob_in_ready;
  logic           fire;

  for (genvar i = 0; i < N; i++) begin : g_in
    elastic_buf #(.W(W), .SLOTS(SLOTS)) ib (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid[i]),
      .in_ready  (in_ready[i]),
      .in_data   (in_data[i*W +: W]),
      .out_valid (q_valid[i]),
      .out_ready (q_ready[i]),
      .out_data  (q_data[i*W +: W])
    );
  end

  rr_arbiter #(.N(N)) arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (q_valid),
    .fire  (fire),
    .gnt   (gnt)
  );

  flit_mux #(.N(N), .W(W)) mux (
    .sel  (gnt),
    .din  (q_data),
    .dout (mux_data)
  );

  // Shared output ready gates every grant; only the winner is acknowledged.
  assign mux_valid = |gnt;
  assign fire      = mux_valid & ob_in_ready;
  assign q_ready   = gnt & {N{ob_in_ready}};
  assign deq       = q_valid & q_ready;

  elastic_buf #(.W(W), .SLOTS(SLOTS)) ob (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mux_valid),
    .in_ready  (ob_in_ready),
    .in_data   (mux_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  assert_one_deq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(deq));
  assert_deq_gnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (deq & ~gnt) == '0);
  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ob_in_ready |-> (deq == '0));
  assert_fire_deq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $countones(deq) == 1);

endmodule

// File: tb/many_to_one_switch_tb_top.sv
`timescale 1ns/1ps
module many_to_one_switch_tb_top;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]   in_valid, in_ready;
  logic [N*W-1:0] in_data;
  logic           out_valid, out_ready;
  logic [W-1:0]   out_data;

  logic [1:0]     v1, rdy1;
  logic [2*W-1:0] d1;
  logic           ov1, or1;
  logic [W-1:0]   od1;

  many_to_one_switch #(.N_PORTS(N), .FLIT_W(W), .SLOTS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  many_to_one_switch #(.N_PORTS(2), .FLIT_W(W), .SLOTS(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(rdy1),
    .in_data(d1), .out_valid(ov1), .out_ready(or1), .out_data(od1));

  int tests = 0, fails = 0;
  int vmode [N];
  int rmode = 0;
  int seq [N], sent [N], rcvd [N], expq [N];
  logic pend [N];
  int nout = 0;
  int ids [64];
  logic en1 = 1'b0;
  int s1 = 0;
  logic p1 = 1'b0;
  logic finished = 1'b0;

  // Bench-side vectors: {mask of backlogged inputs, first four output ids as nibbles, id0 lowest}
  localparam logic [19:0] VEC [6] = '{
    {4'b1111, 16'h3210}, {4'b1010, 16'h3131}, {4'b0100, 16'h2222},
    {4'b1001, 16'h3030}, {4'b0110, 16'h2121}, {4'b1110, 16'h1321}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) vmode[i] = 0;
    rmode = 0; en1 = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) begin
      seq[i] = 0; sent[i] = 0; rcvd[i] = 0; expq[i] = 0; pend[i] = 1'b0;
    end
    nout = 0; s1 = 0; p1 = 1'b0;
    for (int k = 0; k < 64; k++) ids[k] = -1;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  // Port driver and scoreboard, acting on falling edges only.
  initial begin
    in_valid = '0; in_data = '0; out_ready = 1'b0;
    v1 = '0; d1 = '0; or1 = 1'b0;
    for (int i = 0; i < N; i++) begin
      vmode[i] = 0; seq[i] = 0; sent[i] = 0; rcvd[i] = 0; expq[i] = 0; pend[i] = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        in_valid = '0; out_ready = 1'b0; v1 = '0; or1 = 1'b0; p1 = 1'b0;
        for (int i = 0; i < N; i++) pend[i] = 1'b0;
      end else begin
        for (int i = 0; i < N; i++) begin
          logic v;
          if (pend[i]) begin seq[i]++; sent[i]++; end
          case (vmode[i])
            0:       v = 1'b0;
            1:       v = 1'b1;
            default: v = (in_valid[i] && !pend[i]) ? 1'b1 : ($urandom_range(1, 0) == 1);
          endcase
          in_valid[i] = v;
          in_data[i*W +: W] = {4'(i), 12'(seq[i])};
          pend[i] = v & in_ready[i];
        end
        begin
          logic r;
          int id, s;
          r = (rmode == 0) ? 1'b0 : (rmode == 1) ? 1'b1 : ($urandom_range(1, 0) == 1);
          out_ready = r;
          if (out_valid && r) begin
            id = int'(out_data[15:12]);
            s  = int'(out_data[11:0]);
            if (nout < 64) ids[nout] = id;
            nout++;
            chk(id < N, "R6 id", id, N - 1);
            if (id < N) begin
              chk(s == (expq[id] % 4096), "R6 order", s, expq[id] % 4096);
              expq[id]++; rcvd[id]++;
            end
          end
        end
        if (p1) s1++;
        v1  = {1'b0, en1};
        d1  = {16'h0, 16'(s1)};
        p1  = en1 & rdy1[0];
        or1 = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 4'hF, "R1 in_ready", int'(in_ready), 15);
    chk(ov1 == 1'b0, "R1 out_valid slot1", int'(ov1), 0);

    // Vector table: backlogged masks with expected first grant sequence (R2 R3 R7)
    for (int t = 0; t < 6; t++) begin
      do_reset();
      for (int i = 0; i < N; i++) vmode[i] = VEC[t][16+i] ? 1 : 0;
      rmode = 1;
      for (int k = 0; k < 60 && nout < 4; k++) wait_cyc(1);
      for (int i = 0; i < N; i++) vmode[i] = 0;
      for (int k = 0; k < 4; k++)
        chk(ids[k] == int'(VEC[t][4*k +: 4]), "R2 R3 R7 sequence", ids[k], int'(VEC[t][4*k +: 4]));
    end

    // Stall: output full, nothing consumed, priority frozen (R4)
    do_reset();
    for (int i = 0; i < N; i++) vmode[i] = 1;
    rmode = 0;
    wait_cyc(30);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 held valid", int'(out_valid), 1);
    chk(out_data == 16'h0000, "R4 held data", int'(out_data), 0);
    chk(in_ready == 4'h0, "R4 no dequeue", int'(in_ready), 0);
    wait_cyc(5);
    @(negedge clk);
    chk(out_data == 16'h0000, "R4 stable data", int'(out_data), 0);
    chk(nout == 0, "R4 nothing taken", nout, 0);
    // One-cycle release: exactly one input buffer frees, and it is input 2 (R5 R3)
    @(posedge clk); #1; rmode = 1;
    @(posedge clk); #1; rmode = 0;
    @(posedge clk); #1;
    chk(in_ready == 4'b0100, "R5 single dequeue", int'(in_ready), 4);
    rmode = 1;
    wait_cyc(20);
    for (int k = 0; k < 9; k++)
      chk(ids[k] == k % 4, "R4 R3 order after stall", ids[k], k % 4);

    // Throughput: 2-slot sustains one per cycle (R8), 1-slot alternates (R9)
    do_reset();
    vmode[0] = 1; rmode = 1; en1 = 1'b1;
    wait_cyc(10);
    begin
      int hi = 0, hi1 = 0, back = 0;
      logic prev = 1'b0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (out_valid) hi++;
        if (ov1) hi1++;
        if (ov1 && prev) back++;
        prev = ov1;
      end
      chk(hi == 30, "R8 full rate", hi, 30);
      chk(back == 0, "R9 no back-to-back", back, 0);
      chk(hi1 >= 14, "R9 half rate", hi1, 15);
    end
    chk(od1 != 16'hFFFF, "R9 data sane", int'(od1), 0);

    // Random valid and stalls on all inputs, then drain (R6)
    do_reset();
    for (int i = 0; i < N; i++) vmode[i] = 2;
    rmode = 2;
    wait_cyc(3000);
    for (int i = 0; i < N; i++) vmode[i] = 0;
    rmode = 1;
    wait_cyc(60);
    for (int i = 0; i < N; i++) begin
      chk(sent[i] > 0, "R6 traffic", sent[i], 1);
      chk(sent[i] == rcvd[i], "R6 no loss or duplicate", rcvd[i], sent[i]);
    end

    // Mixed pattern: one always-on input among random ones (R6 R7)
    do_reset();
    vmode[0] = 2; vmode[1] = 1; vmode[2] = 0; vmode[3] = 2;
    rmode = 2;
    wait_cyc(2000);
    for (int i = 0; i < N; i++) vmode[i] = 0;
    rmode = 1;
    wait_cyc(60);
    for (int i = 0; i < N; i++)
      chk(sent[i] == rcvd[i], "R6 mixed count", rcvd[i], sent[i]);
    chk(rcvd[1] >= rcvd[0] && rcvd[1] >= rcvd[3], "R7 backlogged input served", rcvd[1], rcvd[0]);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule